// File: doc/BRIEF.md
# Multi-level interrupt vector arbiter

The block gathers device interrupt requests on four priority levels of 32 request lines each. It keeps a pending bit for every line and drives one request line per level towards the host. When the host reads a level's vector, the block takes the lowest-numbered pending line on that level, retires it, and returns the 16-bit vector stored for that line. A configuration port loads the vector table.

Request forwarding and vector delivery are gated by four controls. A diagnostic interrupt disable and a bus-init-in-progress indication must both be low. Two enable controls, a field-interrupt enable and a bus-request interrupt enable, must both be high. The adapter's own interrupt flag is separate from this gating. The flag is raised by a set pulse. It always drives the request line of one designated level. A vector read on that level reports the flag in bit 31 and clears it.

Top module: `irq_vec_arb`

## Requirements
- R1: After reset all pending bits and the adapter flag are clear, `lvl_req_o` is 0 and `rd_data_o` is 0.
- R2: The gate is open when `diag_dis_i`=0, `bus_init_i`=0, `field_en_i`=1 and `br_en_i`=1. Bit l of `lvl_req_o` is then 1 whenever level l has a pending line. When the gate is closed, only the adapter flag can drive a level request.
- R3: With the gate open, a read (`rd_en_i`, level `rd_lvl_i`) on a level with pending lines clears the lowest-numbered pending line. In the cycle after the read, `rd_data_o[15:0]` holds that line's vector, and bits 30:16 are 0.
- R4: A read on level `ADAP_LVL` (default 1) while the adapter flag is set returns bit 31 = 1 and clears the flag.
- R5: A read with the gate closed, or on a level with nothing pending, returns bits 15:0 = 0 and retires nothing. Bit 31 follows R4.
- R6: While the adapter flag is set, bit `ADAP_LVL` of `lvl_req_o` is 1, whatever the gate state.
- R7: If a set pulse on `req_set_i` hits the same line that a read retires in that cycle, the line stays pending.
- R8: A configuration write (`cfg_we_i`, `cfg_lvl_i`, `cfg_line_i`, `cfg_data_i`) replaces one table entry. Reads issued in later cycles return the new value.
- R9: An `adap_set_i` pulse in the same cycle as a flag-clearing read leaves the flag set.
- R10: A read on any level other than `ADAP_LVL` leaves the adapter flag unchanged and returns bit 31 = 0.
- R11: `rd_data_o` changes only in the cycle after a read and otherwise holds its value. Line l of level v is set by `req_set_i[v*32+l]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_set_i | input | 128 | Per-line request set pulses, bit v*32+l |
| adap_set_i | input | 1 | Adapter interrupt flag set pulse |
| diag_dis_i | input | 1 | Diagnostic interrupt disable |
| bus_init_i | input | 1 | Bus initialisation in progress |
| field_en_i | input | 1 | Field interrupt enable |
| br_en_i | input | 1 | Bus-request interrupt enable |
| cfg_we_i | input | 1 | Vector table write strobe |
| cfg_lvl_i | input | 2 | Vector table write level |
| cfg_line_i | input | 5 | Vector table write line |
| cfg_data_i | input | 16 | Vector table write data |
| rd_en_i | input | 1 | Vector read strobe |
| rd_lvl_i | input | 2 | Level being read |
| lvl_req_o | output | 4 | Per-level request to host |
| rd_data_o | output | 32 | Vector read result |

## Verification
A wrong pending bit shows on `lvl_req_o` in the same cycle under an open gate. It also shows on the next read of that level, as a wrong vector in `rd_data_o` one cycle after the read. A lost or stuck adapter flag shows on the designated level's request line at once, regardless of the gate. It also shows in bit 31 of the next read on that level. Wrong priority appears as an out-of-order vector sequence when several lines on one level are drained in turn. Set-versus-clear races appear when the retired line is read again.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned DEF_LVLS   = 4;
  localparam int unsigned DEF_LINES  = 32;
  localparam int unsigned DEF_VEC_W  = 16;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_ADAP   = 1;

  typedef struct packed {
    logic diag_dis;
    logic bus_init;
    logic field_en;
    logic br_en;
  } gate_ctl_t;

  function automatic logic gate_open(gate_ctl_t g);
    return !g.diag_dis && !g.bus_init && g.field_en && g.br_en;
  endfunction
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic [W-1:0]  oh_o,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    valid_o = |req_i;
    oh_o    = valid_o ? (W'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] set_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] pend_o
);
  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int unsigned LVLS  = 4,
  parameter int unsigned LINES = 32,
  parameter int unsigned VEC_W = 16,
  localparam int unsigned LW = $clog2(LVLS),
  localparam int unsigned IW = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LW-1:0]    wr_lvl_i,
  input  logic [IW-1:0]    wr_line_i,
  input  logic [VEC_W-1:0] wr_data_i,
  input  logic [LW-1:0]    rd_lvl_i,
  input  logic [IW-1:0]    rd_line_i,
  output logic [VEC_W-1:0] rd_data_o
);
  logic [VEC_W-1:0] mem_q [LVLS][LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int v = 0; v < LVLS; v++)
        for (int l = 0; l < LINES; l++) mem_q[v][l] <= '0;
    end else if (we_i) begin
      mem_q[wr_lvl_i][wr_line_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_lvl_i][rd_line_i];
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_vec_pkg::*;
#(
  parameter int unsigned LVLS     = DEF_LVLS,
  parameter int unsigned LINES    = DEF_LINES,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned ADAP_LVL = DEF_ADAP,
  localparam int unsigned LW = $clog2(LVLS),
  localparam int unsigned IW = $clog2(LINES),
  localparam int unsigned NREQ = LVLS * LINES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NREQ-1:0]   req_set_i,
  input  logic              adap_set_i,
  input  logic              diag_dis_i,
  input  logic              bus_init_i,
  input  logic              field_en_i,
  input  logic              br_en_i,
  input  logic              cfg_we_i,
  input  logic [LW-1:0]     cfg_lvl_i,
  input  logic [IW-1:0]     cfg_line_i,
  input  logic [VEC_W-1:0]  cfg_data_i,
  input  logic              rd_en_i,
  input  logic [LW-1:0]     rd_lvl_i,
  output logic [LVLS-1:0]   lvl_req_o,
  output logic [DATA_W-1:0] rd_data_o
);
  gate_ctl_t        gate_ctl;
  logic             gate;
  logic [LINES-1:0] pend   [LVLS];
  logic [NREQ-1:0]  pend_flat;
  logic [LINES-1:0] sel_pend, pick_oh;
  logic [IW-1:0]    pick_idx;
  logic             pick_valid, consume, flag_hit;
  logic             adap_flag_q;
  logic [VEC_W-1:0] vec_rd;
  logic [DATA_W-1:0] rd_data_d;

  assign gate_ctl = '{diag_dis: diag_dis_i, bus_init: bus_init_i,
                      field_en: field_en_i, br_en: br_en_i};
  assign gate     = gate_open(gate_ctl);
  assign sel_pend = pend[rd_lvl_i];

  irq_lowest_pick #(.W(LINES)) pick_i (
    .req_i(sel_pend), .oh_o(pick_oh), .idx_o(pick_idx), .valid_o(pick_valid)
  );

  assign consume  = rd_en_i && gate && pick_valid;
  assign flag_hit = rd_en_i && (rd_lvl_i == LW'(ADAP_LVL)) && adap_flag_q;

  for (genvar v = 0; v < LVLS; v++) begin : g_lvl
    logic [LINES-1:0] clr;
    assign clr = (consume && rd_lvl_i == LW'(v)) ? pick_oh : '0;

    irq_pend_bank #(.LINES(LINES)) bank_i (
      .clk_i, .rst_ni,
      .set_i (req_set_i[v*LINES +: LINES]),
      .clr_i (clr),
      .pend_o(pend[v])
    );

    assign pend_flat[v*LINES +: LINES] = pend[v];

    if (v == ADAP_LVL) begin : g_adap
      assign lvl_req_o[v] = (gate && |pend[v]) || adap_flag_q;
    end else begin : g_dev
      assign lvl_req_o[v] = gate && |pend[v];
    end
  end

  irq_vec_table #(.LVLS(LVLS), .LINES(LINES), .VEC_W(VEC_W)) tab_i (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i),
    .wr_lvl_i (cfg_lvl_i),
    .wr_line_i(cfg_line_i),
    .wr_data_i(cfg_data_i),
    .rd_lvl_i (rd_lvl_i),
    .rd_line_i(pick_idx),
    .rd_data_o(vec_rd)
  );

  always_comb begin
    rd_data_d = '0;
    rd_data_d[DATA_W-1] = flag_hit;
    if (consume) rd_data_d[VEC_W-1:0] = vec_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adap_flag_q <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      adap_flag_q <= adap_set_i || (adap_flag_q && !flag_hit);
      if (rd_en_i) rd_data_o <= rd_data_d;
    end
  end
endmodule

// File: rtl/irq_vec_arb_chk.sv
module irq_vec_arb_chk #(
  parameter int unsigned LVLS     = 4,
  parameter int unsigned LINES    = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADAP_LVL = 1,
  localparam int unsigned LW = $clog2(LVLS),
  localparam int unsigned NREQ = LVLS * LINES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NREQ-1:0]   req_set_i,
  input logic              adap_set_i,
  input logic              diag_dis_i,
  input logic              bus_init_i,
  input logic              field_en_i,
  input logic              br_en_i,
  input logic              rd_en_i,
  input logic [LW-1:0]     rd_lvl_i,
  input logic [LVLS-1:0]   lvl_req_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              adap_flag_q,
  input logic [NREQ-1:0]   pend_flat
);
  logic gate_ok;
  logic [LINES-1:0] sel_pend, sel_set;
  logic [LVLS-1:0] non_adap;
  int unsigned cnt_sel, cnt_prev;
  logic drain_prev;
  logic [LW-1:0] lvl_prev;

  assign gate_ok  = !diag_dis_i && !bus_init_i && field_en_i && br_en_i;
  assign sel_pend = pend_flat[rd_lvl_i*LINES +: LINES];
  assign sel_set  = req_set_i[rd_lvl_i*LINES +: LINES];
  assign non_adap = ~(LVLS'(1) << ADAP_LVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_prev <= 1'b0;
      cnt_prev   <= 0;
      lvl_prev   <= '0;
    end else begin
      drain_prev <= rd_en_i && gate_ok && (|sel_pend) && !(|sel_set);
      cnt_prev   <= $countones(sel_pend);
      lvl_prev   <= rd_lvl_i;
    end
  end
  assign cnt_sel = $countones(pend_flat[lvl_prev*LINES +: LINES]);

  // R2
  gate_closed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_ok |-> ((lvl_req_o & non_adap) == '0));
  // R6
  adap_flag_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adap_flag_q |-> lvl_req_o[ADAP_LVL]);
  // R3
  drain_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_prev |-> (cnt_sel + 1 == cnt_prev));
  // R5
  blocked_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !gate_ok && !adap_flag_q) |=> (rd_data_o == '0));
  // R4
  adap_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_lvl_i == LW'(ADAP_LVL) && adap_flag_q && !adap_set_i)
      |=> (rd_data_o[DATA_W-1] && !adap_flag_q));
  // R10
  other_lvl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_lvl_i != LW'(ADAP_LVL) && adap_flag_q)
      |=> (!rd_data_o[DATA_W-1] && adap_flag_q));
endmodule

bind irq_vec_arb irq_vec_arb_chk #(
  .LVLS(LVLS), .LINES(LINES), .DATA_W(DATA_W), .ADAP_LVL(ADAP_LVL)
) chk_i (
  .clk_i, .rst_ni, .req_set_i, .adap_set_i, .diag_dis_i, .bus_init_i,
  .field_en_i, .br_en_i, .rd_en_i, .rd_lvl_i, .lvl_req_o, .rd_data_o,
  .adap_flag_q, .pend_flat
);

// File: tb/irq_vec_arb_tb_top.sv
module irq_vec_arb_tb_top;
  localparam int ADAP = 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [127:0] req_set_i = '0;
  logic        adap_set_i = 0, diag_dis_i = 0, bus_init_i = 0;
  logic        field_en_i = 1, br_en_i = 1;
  logic        cfg_we_i = 0;
  logic [1:0]  cfg_lvl_i = 0;
  logic [4:0]  cfg_line_i = 0;
  logic [15:0] cfg_data_i = 0;
  logic        rd_en_i = 0;
  logic [1:0]  rd_lvl_i = 0;
  logic [3:0]  lvl_req_o;
  logic [31:0] rd_data_o;

  irq_vec_arb dut_i (.*);

  always #2 clk_i = ~clk_i;

  // reference model
  bit [31:0]   m_pend [4];
  bit          m_flag;
  bit [31:0]   m_rd;
  bit [15:0]   m_tab [4][32];
  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  function automatic bit m_gate();
    return !diag_dis_i && !bus_init_i && field_en_i && br_en_i;
  endfunction

  function automatic bit [3:0] m_req();
    bit [3:0] r;
    for (int v = 0; v < 4; v++) r[v] = m_gate() && (m_pend[v] != 0);
    if (m_flag) r[ADAP] = 1'b1;
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (lvl_req_o !== m_req()) begin
      errors++;
      $display("FAIL %s lvl_req actual=%h expected=%h", tag, lvl_req_o, m_req());
    end
    checks++;
    if (rd_data_o !== m_rd) begin
      errors++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data_o, m_rd);
    end
  endtask

  task automatic cyc();
    bit [31:0] np [4];
    bit nf;
    bit [31:0] nrd;
    bit hit;
    int pick;
    for (int v = 0; v < 4; v++) np[v] = m_pend[v];
    nrd = m_rd;
    hit = rd_en_i && rd_lvl_i == 2'(ADAP) && m_flag;
    if (rd_en_i) begin
      nrd = 0;
      nrd[31] = hit;
      pick = -1;
      if (m_gate())
        for (int i = 31; i >= 0; i--) if (m_pend[rd_lvl_i][i]) pick = i;
      if (pick >= 0) begin
        np[rd_lvl_i][pick] = 1'b0;
        nrd[15:0] = m_tab[rd_lvl_i][pick];
      end
    end
    for (int v = 0; v < 4; v++) np[v] |= req_set_i[v*32 +: 32];
    nf = adap_set_i || (m_flag && !hit);
    @(posedge clk_i);
    for (int v = 0; v < 4; v++) m_pend[v] = np[v];
    m_flag = nf; m_rd = nrd;
    if (cfg_we_i) m_tab[cfg_lvl_i][cfg_line_i] = cfg_data_i;
    @(negedge clk_i);
    compare();
    req_set_i = '0; adap_set_i = 0; rd_en_i = 0; cfg_we_i = 0;
  endtask

  task automatic set_line(int v, int l);
    req_set_i[v*32 + l] = 1'b1;
  endtask

  task automatic rd(int v);
    rd_en_i = 1; rd_lvl_i = 2'(v);
  endtask

  task automatic gate(bit dd, bit bi, bit fe, bit be);
    diag_dis_i = dd; bus_init_i = bi; field_en_i = fe; br_en_i = be;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 4; v++) begin
      m_pend[v] = 0;
      for (int l = 0; l < 32; l++) m_tab[v][l] = 0;
    end
    m_flag = 0; m_rd = 0;
    // R1: reset state
    set_line(0, 3); adap_set_i = 1;
    repeat (3) @(negedge clk_i);
    compare();
    rst_ni = 1'b1;
    req_set_i = '0; adap_set_i = 0;
    cyc();

    // R8: load table
    tag = "R8";
    for (int v = 0; v < 4; v++)
      for (int l = 0; l < 32; l++) begin
        cfg_we_i = 1; cfg_lvl_i = 2'(v); cfg_line_i = 5'(l);
        cfg_data_i = 16'h1000 + 16'(v*256 + l*7);
        cyc();
      end

    // R2: forwarding and each gate control
    tag = "R2";
    set_line(0, 9); set_line(2, 31); set_line(3, 0);
    cyc(); cyc();
    gate(1, 0, 1, 1); cyc();
    gate(0, 1, 1, 1); cyc();
    gate(0, 0, 0, 1); cyc();
    gate(0, 0, 1, 0); cyc();
    gate(0, 0, 1, 1); cyc();

    // R3: lowest first drain
    tag = "R3";
    set_line(1, 20); set_line(1, 4); set_line(1, 11); cyc();
    for (int k = 0; k < 4; k++) begin rd(1); cyc(); end
    rd(2); cyc(); rd(0); cyc(); rd(3); cyc();

    // R11: data holds without read
    tag = "R11";
    set_line(2, 5); cyc(); cyc(); cyc();

    // R5: blocked and empty reads
    tag = "R5";
    gate(0, 1, 1, 1); rd(2); cyc(); cyc();
    gate(0, 0, 1, 1); rd(0); cyc();
    rd(2); cyc(); rd(2); cyc();

    // R8: rewrite an entry, read it afterwards
    tag = "R8";
    cfg_we_i = 1; cfg_lvl_i = 3; cfg_line_i = 7; cfg_data_i = 16'hBEEF;
    set_line(3, 7); rd(3); cyc();
    rd(3); cyc();

    // R6: adapter request ignores gate
    tag = "R6";
    adap_set_i = 1; gate(1, 1, 0, 0); cyc(); cyc();
    // R10: other level leaves flag
    tag = "R10";
    rd(0); cyc(); rd(3); cyc();
    // R4: adapter read clears flag, gate closed so bit31 only
    tag = "R4";
    set_line(1, 2); cyc();
    rd(1); cyc(); cyc();
    gate(0, 0, 1, 1); adap_set_i = 1; cyc();
    rd(1); cyc(); rd(1); cyc();

    // R9: set pulse beats clearing read
    tag = "R9";
    adap_set_i = 1; cyc();
    adap_set_i = 1; rd(1); cyc();
    rd(1); cyc(); rd(1); cyc();

    // R7: set beats retire on same line
    tag = "R7";
    set_line(0, 6); cyc();
    set_line(0, 6); rd(0); cyc();
    rd(0); cyc(); rd(0); cyc();

    // R3: mixed random traffic
    tag = "R3";
    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < 3; k++)
        if ($urandom_range(0, 1)) set_line($urandom_range(0, 3), $urandom_range(0, 31));
      if ($urandom_range(0, 2) == 0) rd($urandom_range(0, 3));
      adap_set_i = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 7) == 0)
        gate($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, 1, 1);
      if ($urandom_range(0, 31) == 0) begin
        cfg_we_i = 1; cfg_lvl_i = 2'($urandom_range(0, 3));
        cfg_line_i = 5'($urandom_range(0, 31)); cfg_data_i = 16'($urandom);
      end
      cyc();
    end
    gate(0, 0, 1, 1);
    for (int n = 0; n < 140; n++) begin rd(n % 4); cyc(); end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule